// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block lives inside an SMBus target and handles the alert side of the bus. A one-cycle local event sets an internal pending flag. The pending flag drives the separate active-low alert wire through an open-drain pull-down enable. The host notices the alert and issues a one-byte broadcast read to the reserved alert response address. Every target that has an alert pending acknowledges that read. Each one then tries to return its own 7-bit bus address on the shared data line.

Because the data line is a wired-AND, several responders can send at once. Each responder compares the sampled line with the bit it intends to send. A responder that releases the line but sees it low has lost, and it stays silent for the rest of the byte. The lowest address therefore wins. Only the winner drops its alert. A loser keeps its alert raised and answers again on a later alert response read.

The bus lines enter through synchronisers. The block drives its outputs as pull-down enables, so a `1` means the block pulls the wire low.

Top module: `alert_responder`

## Requirements
- R1: A high `eventIn` sets the pending state, and `alertPullLow` is 1 from the next clock on. It stays 1 until the alert is delivered.
- R2: While an alert is pending, the block acknowledges the address byte 0x19 by pulling SDA low during the ninth SCL pulse. That byte is address 0001100 followed by the read bit 1.
- R3: With no alert pending, the block neither acknowledges the alert response read nor drives SDA during it.
- R4: Any other address byte is ignored. This includes 0x1B and the write form 0x18. The block gives no acknowledge, and `alertPullLow` is unchanged.
- R5: After the acknowledge, the block sends the byte {ownAddr[6:0], 1'b0}, most significant bit first. A released bit reads as 1 and a pulled bit reads as 0.
- R6: The block loses arbitration if it releases SDA and samples it low during a data bit. It then releases SDA for the rest of the byte, pulses `arbLostPulse` for one cycle, and keeps `alertPullLow` at 1. As a result, the lowest address wins.
- R7: Sending all eight bits without a loss pulses `deliveredPulse` for one cycle and clears `alertPullLow`. The only exception is a new event in that same cycle.
- R8: After a lost round, the block answers the next alert response read again.
- R9: The block starts pulling SDA only while SCL is low.
- R10: The block releases the bus after the controller's NACK and returns to idle at STOP. A repeated START restarts address matching.
- R11: During reset, all four outputs are 0.
- R12: `deliveredPulse` and `arbLostPulse` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sensed SCL level |
| sdaIn | input | 1 | Sensed SDA level |
| eventIn | input | 1 | Local alert event, one cycle |
| ownAddr | input | 7 | This target's bus address |
| sdaPullLow | output | 1 | 1 pulls SDA low |
| alertPullLow | output | 1 | 1 pulls the alert wire low |
| deliveredPulse | output | 1 | One-cycle pulse when the address byte was sent without loss |
| arbLostPulse | output | 1 | One-cycle pulse when arbitration was lost |

## Verification
The hardest state to reach from the ports is a lost arbitration in the middle of a byte. Reaching it needs a second responder on the same wired-AND line, with an address that differs from the block's own address at some bit. The bench models that competitor inside its bus tasks. The competitor acknowledges, drives its own address bits, and drops out by the same rule the block uses. Random pairs of addresses and pending states then move the first differing bit across all positions, including equal addresses, where both responders win.

// File: rtl/alrt_pkg.sv
package alrt_pkg;
  localparam int ADDR_BITS = 7;
  localparam int BYTE_BITS = ADDR_BITS + 1;
  localparam int CNT_W     = $clog2(BYTE_BITS);
  localparam logic [ADDR_BITS-1:0] ALERT_ADDR      = 7'b0001100;
  localparam logic [BYTE_BITS-1:0] ALERT_READ_BYTE = {ALERT_ADDR, 1'b1};

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACKPREP, ST_ACKHOLD, ST_SEND, ST_HOSTACK, ST_WAITSTOP
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic capture;
    logic loadTx;
    logic shiftTx;
    logic driveAck;
    logic releaseSda;
    logic deliver;
    logic lost;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic cntLast;
    logic addrHit;
    logic txBit;
    logic sdaLvl;
    logic pending;
  } status_t;
endpackage

// File: rtl/alrt_datapath.sv
module alrt_datapath
  import alrt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic                 eventIn,
  input  logic [ADDR_BITS-1:0] ownAddr,
  input  strobe_t              stb,
  output status_t              sts,
  output logic                 sdaPullLow,
  output logic                 alertPullLow,
  output logic                 deliveredPulse,
  output logic                 arbLostPulse,
  output logic                 sclLvl
);
  localparam int SYNC_N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SYNC_N-1:0]    sclSh, sdaSh;
  logic                 sclPrev, sdaPrev;
  logic                 sclS, sdaS;
  logic [BYTE_BITS-1:0] rxByte;
  logic [BYTE_BITS-1:0] txShift;
  logic [CNT_W-1:0]     bitCnt;
  logic                 pending;

  // input synchronisers, idle-high reset value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSh   <= '1;
      sdaSh   <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSh   <= {sclSh[SYNC_N-2:0], sclIn};
      sdaSh   <= {sdaSh[SYNC_N-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS   = sclSh[SYNC_N-1];
  assign sdaS   = sdaSh[SYNC_N-1];
  assign sclLvl = sclS;

  // receive shifter and bit counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte <= '0;
      bitCnt <= '0;
    end else begin
      if (stb.capture) rxByte <= {rxByte[BYTE_BITS-2:0], sdaS};
      if (stb.clrCnt)       bitCnt <= '0;
      else if (stb.incCnt)  bitCnt <= bitCnt + 1'b1;
    end
  end

  // transmit shifter and open-drain data enable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift    <= '1;
      sdaPullLow <= 1'b0;
    end else begin
      if (stb.loadTx)       txShift <= {ownAddr, 1'b0};
      else if (stb.shiftTx) txShift <= {txShift[BYTE_BITS-2:0], 1'b1};

      if (stb.releaseSda)    sdaPullLow <= 1'b0;
      else if (stb.driveAck) sdaPullLow <= 1'b1;
      else if (stb.loadTx)   sdaPullLow <= ~ownAddr[ADDR_BITS-1];
      else if (stb.shiftTx)  sdaPullLow <= ~txShift[BYTE_BITS-2];
    end
  end

  // alert pending state and status pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending        <= 1'b0;
      deliveredPulse <= 1'b0;
      arbLostPulse   <= 1'b0;
    end else begin
      pending        <= eventIn | (pending & ~stb.deliver);
      deliveredPulse <= stb.deliver;
      arbLostPulse   <= stb.lost;
    end
  end

  assign alertPullLow = pending;

  always_comb begin
    sts.sclRise   = sclS & ~sclPrev;
    sts.sclFall   = ~sclS & sclPrev;
    sts.startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
    sts.stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;
    sts.cntLast   = (bitCnt == CNT_W'(BYTE_BITS - 1));
    sts.addrHit   = ({rxByte[BYTE_BITS-2:0], sdaS} == ALERT_READ_BYTE);
    sts.txBit     = txShift[BYTE_BITS-1];
    sts.sdaLvl    = sdaS;
    sts.pending   = pending;
  end
endmodule

// File: rtl/alrt_control.sv
module alrt_control
  import alrt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  status_t sts,
  output strobe_t stb
);
  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    if (sts.stopSeen) begin
      stb.releaseSda = 1'b1;
      stateNext      = ST_IDLE;
    end else if (sts.startSeen) begin
      stb.releaseSda = 1'b1;
      stb.clrCnt     = 1'b1;
      stateNext      = ST_ADDR;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (sts.sclRise) begin
            stb.capture = 1'b1;
            if (sts.cntLast) begin
              stb.clrCnt = 1'b1;
              stateNext  = (sts.addrHit && sts.pending) ? ST_ACKPREP : ST_WAITSTOP;
            end else begin
              stb.incCnt = 1'b1;
            end
          end
        end
        ST_ACKPREP: begin
          if (sts.sclFall) begin
            stb.driveAck = 1'b1;
            stateNext    = ST_ACKHOLD;
          end
        end
        ST_ACKHOLD: begin
          if (sts.sclFall) begin
            stb.loadTx = 1'b1;
            stb.clrCnt = 1'b1;
            stateNext  = ST_SEND;
          end
        end
        ST_SEND: begin
          if (sts.sclRise) begin
            if (sts.txBit && !sts.sdaLvl) begin
              stb.lost       = 1'b1;
              stb.releaseSda = 1'b1;
              stateNext      = ST_WAITSTOP;
            end else if (sts.cntLast) begin
              stb.deliver = 1'b1;
              stateNext   = ST_HOSTACK;
            end else begin
              stb.incCnt = 1'b1;
            end
          end else if (sts.sclFall) begin
            stb.shiftTx = 1'b1;
          end
        end
        ST_HOSTACK: begin
          if (sts.sclFall) begin
            stb.releaseSda = 1'b1;
            stateNext      = ST_WAITSTOP;
          end
        end
        ST_WAITSTOP: ;
        default: stateNext = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/alert_responder.sv
module alert_responder
  import alrt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic                 eventIn,
  input  logic [ADDR_BITS-1:0] ownAddr,
  output logic                 sdaPullLow,
  output logic                 alertPullLow,
  output logic                 deliveredPulse,
  output logic                 arbLostPulse
);
  strobe_t stb;
  status_t sts;
  logic    sclLvl;

  alrt_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .eventIn(eventIn),
    .ownAddr(ownAddr), .stb(stb), .sts(sts), .sdaPullLow(sdaPullLow),
    .alertPullLow(alertPullLow), .deliveredPulse(deliveredPulse),
    .arbLostPulse(arbLostPulse), .sclLvl(sclLvl)
  );

  alrt_control u_ctl (
    .clk(clk), .rstN(rstN), .sts(sts), .stb(stb)
  );
endmodule

// File: rtl/alert_responder_sva.sv
module alert_responder_sva (
  input logic clk,
  input logic rstN,
  input logic eventIn,
  input logic sclLvl,
  input logic sdaPullLow,
  input logic alertPullLow,
  input logic deliveredPulse,
  input logic arbLostPulse
);
  // R1: an event raises the alert on the next clock
  a_r1_event_raises: assert property (@(posedge clk) disable iff (!rstN)
    eventIn |=> alertPullLow);

  // R2: SDA is only pulled while an alert is pending
  a_r2_drive_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> alertPullLow);

  // R6: a loss keeps the alert and leaves SDA released
  a_r6_loss_keeps_alert: assert property (@(posedge clk) disable iff (!rstN)
    arbLostPulse |-> (alertPullLow && !sdaPullLow));

  // R7: delivery clears the alert unless a fresh event arrived
  a_r7_deliver_clears: assert property (@(posedge clk) disable iff (!rstN)
    (deliveredPulse && !$past(eventIn)) |-> !alertPullLow);

  // R9: SDA pull-down begins only with SCL low
  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclLvl);

  // R12: the two status pulses are exclusive
  a_r12_pulses_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({deliveredPulse, arbLostPulse}));
endmodule

bind alert_responder alert_responder_sva u_sva (
  .clk(clk), .rstN(rstN), .eventIn(eventIn), .sclLvl(sclLvl),
  .sdaPullLow(sdaPullLow), .alertPullLow(alertPullLow),
  .deliveredPulse(deliveredPulse), .arbLostPulse(arbLostPulse)
);

// File: tb/sim_alert_responder.sv
module sim_alert_responder;
  localparam int H = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN = 1'b0;
  logic       sclLine = 1'b1;
  logic       hostPull = 1'b0;
  logic       compPull = 1'b0;
  logic       eventIn = 1'b0;
  logic [6:0] ownAddr = 7'h2A;
  logic       dutPull, alertPull, delivered, arbLost;
  wire        sdaLine = ~(hostPull | compPull | dutPull);

  int checks = 0, errors = 0;
  int delivCnt = 0, lostCnt = 0, riseViol = 0;
  logic prevPull = 1'b0;
  bit done = 0;

  alert_responder u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine), .eventIn(eventIn),
    .ownAddr(ownAddr), .sdaPullLow(dutPull), .alertPullLow(alertPull),
    .deliveredPulse(delivered), .arbLostPulse(arbLost)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (delivered) delivCnt++;
      if (arbLost) lostCnt++;
      if (dutPull && !prevPull && sclLine) riseViol++;
    end
    prevPull = dutPull;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    hostPull = 0; compPull = 0; sclLine = 1; waitc(H);
    hostPull = 1; waitc(H); sclLine = 0;
  endtask

  task automatic busRestart();
    waitc(4); hostPull = 0; compPull = 0; waitc(H); sclLine = 1; waitc(H);
    hostPull = 1; waitc(H); sclLine = 0;
  endtask

  task automatic busStop();
    waitc(4); hostPull = 1; compPull = 0; waitc(H); sclLine = 1; waitc(H);
    hostPull = 0; waitc(H);
  endtask

  task automatic sendBit(input bit b);
    waitc(4); hostPull = ~b; compPull = 0; waitc(H);
    sclLine = 1; waitc(H); sclLine = 0;
  endtask

  task automatic readBit(input bit compDrv, output bit v);
    waitc(4); hostPull = 0; compPull = compDrv; waitc(H);
    sclLine = 1; waitc(H/2); v = sdaLine; waitc(H/2); sclLine = 0;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit compAck, output bit ackBit);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    readBit(compAck, ackBit);
  endtask

  task automatic readByte(input bit compIn, input logic [7:0] compByte, output logic [7:0] got);
    bit alive = compIn;
    bit v;
    for (int i = 7; i >= 0; i--) begin
      readBit(alive && !compByte[i], v);
      got[i] = v;
      if (alive && compByte[i] && !v) alive = 0;
    end
  endtask

  task automatic alertTxn(input bit compIn, input logic [6:0] compAddr,
                          output bit acked, output logic [7:0] got);
    bit a;
    busStart();
    sendByte(8'h19, compIn, a);
    acked = !a;
    got = 8'hFF;
    if (acked) begin
      readByte(compIn, {compAddr, 1'b0}, got);
      sendBit(1'b1);
    end
    busStop();
  endtask

  task automatic raise();
    eventIn = 1; waitc(1); eventIn = 0; waitc(2);
  endtask

  function automatic logic [7:0] expByte(bit d, logic [6:0] da, bit c, logic [6:0] ca);
    logic [7:0] x = {da, 1'b0};
    logic [7:0] y = {ca, 1'b0};
    if (d && c) return (x < y) ? x : y;
    if (d) return x;
    if (c) return y;
    return 8'hFF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acked, a;
    logic [7:0] got;
    int d0, l0;
    bit modelPend = 0;
    void'($urandom(32'd1234));

    waitc(5);
    chk("R11 sda", dutPull, 0); chk("R11 alert", alertPull, 0);
    chk("R11 deliv", delivered, 0); chk("R11 lost", arbLost, 0);
    rstN = 1; waitc(4);

    // R3: nothing pending
    alertTxn(0, 7'h0, acked, got);
    chk("R3 no ack", acked, 0); chk("R3 byte", got, 8'hFF); chk("R3 alert", alertPull, 0);

    // R1
    raise();
    chk("R1 alert set", alertPull, 1);
    waitc(20);
    chk("R1 alert held", alertPull, 1);

    // R4: other address and write direction
    busStart(); sendByte(8'h1B, 0, a); busStop();
    chk("R4 other addr no ack", a, 1);
    busStart(); sendByte(8'h18, 0, a); busStop();
    chk("R4 write no ack", a, 1);
    chk("R4 alert kept", alertPull, 1);

    // R2, R5, R7: lone responder wins
    ownAddr = 7'h2A; d0 = delivCnt;
    alertTxn(0, 7'h0, acked, got);
    chk("R2 ack", acked, 1); chk("R5 byte", got, 8'h54);
    chk("R7 deliv pulse", delivCnt - d0, 1); chk("R7 alert cleared", alertPull, 0);

    // R6: lower competitor wins
    ownAddr = 7'h40; raise(); d0 = delivCnt; l0 = lostCnt;
    alertTxn(1, 7'h21, acked, got);
    chk("R6 byte", got, 8'h42); chk("R6 lost pulse", lostCnt - l0, 1);
    chk("R6 alert kept", alertPull, 1); chk("R6 no deliv", delivCnt - d0, 0);

    // R8: retry alone
    d0 = delivCnt;
    alertTxn(0, 7'h0, acked, got);
    chk("R8 ack", acked, 1); chk("R8 byte", got, 8'h80);
    chk("R8 deliv", delivCnt - d0, 1); chk("R8 alert cleared", alertPull, 0);

    // R10: repeated START after an ignored address
    ownAddr = 7'h11; raise();
    busStart(); sendByte(8'hA0, 0, a);
    chk("R10 first addr ignored", a, 1);
    busRestart(); sendByte(8'h19, 0, a);
    chk("R10 ack after restart", a, 0);
    readByte(0, 8'h0, got); sendBit(1'b1); busStop();
    chk("R10 byte", got, 8'h22); chk("R10 alert cleared", alertPull, 0);
    chk("R10 sda released", dutPull, 0);

    // random rounds
    for (int it = 0; it < 24; it++) begin
      bit pend, compIn, win, lose;
      logic [6:0] comp;
      ownAddr = 7'($urandom % 128);
      comp    = 7'($urandom % 128);
      if (it % 5 == 0) comp = ownAddr;
      pend   = 1'($urandom % 2);
      compIn = 1'($urandom % 2);
      if (pend) raise();
      modelPend = modelPend | pend;
      win  = modelPend && (!compIn || ownAddr <= comp);
      lose = modelPend && compIn && (comp < ownAddr);
      d0 = delivCnt; l0 = lostCnt;
      alertTxn(compIn, comp, acked, got);
      chk("R2 rand ack", acked, int'(modelPend | compIn));
      chk("R6 rand byte", got, expByte(modelPend, ownAddr, compIn, comp));
      chk("R7 rand deliv", delivCnt - d0, int'(win));
      chk("R6 rand lost", lostCnt - l0, int'(lose));
      if (win) modelPend = 0;
      chk("R8 rand alert", alertPull, int'(modelPend));
    end

    chk("R9 rise with scl high", riseViol, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule